// File: doc/BRIEF.md
# Ringing Cadence and Ring-Trip Sequencer

This block sits between a line-card controller and the analog line driver of a telephone subscriber line. The controller writes a three-bit command word. The block decodes that word into a ringing-mode indication and a ringing request. It then raises or lowers a ringing enable toward the driver. The enable changes only on a zero-crossing pulse taken from the reference ringing waveform, so every burst starts and ends at a zero crossing.

While ringing is armed, the driver may report that the loop has closed because the handset was lifted. The block then cuts the ringing enable at once and keeps ringing mode asserted. It then counts zero-crossing pulses for as long as the loop stays closed. Four pulses, which span two ringing periods, confirm the trip. A confirmed trip sets a status flag and keeps ringing off until the controller writes a new command. If the loop opens before the count completes, the flag stays clear and ringing resumes at the next zero crossing.

The window is measured in pulses, not clock cycles, so it follows the reference frequency anywhere in the 16 Hz to 66 Hz range. Analog signal generation, DC offset and battery selection are handled elsewhere.

Top module: `ring_cadence_seq`

## Requirements
- R1: Command bit 0 is the mode-exclusion bit, bit 1 is the ringing-request bit and bit 2 is the ringing-select bit. `ring_mode` is 1 exactly when the last written command has bit 2 = 1 and bit 0 = 0, and it is valid on the cycle after the write strobe.
- R2: Ringing is requested only when `ring_mode` is 1 and command bit 1 is 1. For every other command value `ring_en` stays 0 across zero-crossing pulses.
- R3: `ring_en` rises only on the clock edge that samples `zc_pulse` = 1. A requested start waits for that pulse, with no limit on how long it waits.
- R4: When a command write withdraws the request, `ring_en` stays 1 until the edge that samples the next `zc_pulse`, and falls there.
- R5: If `loop_closed` is sampled as 1 while ringing is armed, `ring_en` is 0 by the second clock edge after that sample, and `ring_mode` stays 1.
- R6: The trip is confirmed on the edge that samples the fourth `zc_pulse` (parameter ZC_PER_WINDOW, default 4, which spans two ringing periods) while `loop_closed` has been 1 continuously since the closure began. `trip_flag` becomes 1 at that edge and not before.
- R7: If `loop_closed` drops before confirmation, `trip_flag` stays 0, `ring_en` stays 0 until the next `zc_pulse`, and ringing then resumes.
- R8: After a confirmed trip, `ring_en` stays 0 and `trip_flag` stays 1 through any number of zero-crossing pulses and any change of `loop_closed`, until a command write.
- R9: Any command write clears `trip_flag` on the edge that samples the strobe and returns the sequencer to idle. If the new command requests ringing, `ring_en` restarts at the next `zc_pulse`.
- R10: The confirmation outcome depends only on the number of pulses, not on their spacing in clock cycles. The same pulse count gives the same result for short and long pulse gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | One-cycle command write strobe |
| cmd_data | input | 3 | Command word (bit 2 select, bit 1 request, bit 0 exclusion) |
| zc_pulse | input | 1 | One-cycle pulse at each zero crossing of the reference ringing waveform |
| loop_closed | input | 1 | Loop-closure (off-hook) indication from the line driver, synchronous |
| ring_en | output | 1 | Ringing injection enable toward the line driver |
| ring_mode | output | 1 | Ringing mode decoded from the command |
| trip_flag | output | 1 | Status bit 0: ring trip confirmed |

## Verification
The assertions assume that `zc_pulse` is high for one cycle at a time, that `loop_closed` is already synchronous to `clk`, and that `cmd_data` holds steady while `cmd_we` is high. The stimulus changes every input only on falling clock edges. It drives each zero-crossing pulse for exactly one cycle, with gaps of at least two cycles. It also places each command write on a single cycle with stable data. Inside those limits, the bench sweeps all eight command values and every possible abort point of the confirmation window, at two pulse spacings.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int CMD_W       = 3;
    localparam int CMD_EXCL    = 0;
    localparam int CMD_REQ     = 1;
    localparam int CMD_SEL     = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMED   = 2'd1,
        SEQ_CHECK   = 2'd2,
        SEQ_TRIPPED = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ring_cmd_reg.sv
module ring_cmd_reg
    import ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             ring_mode,
    output logic             ring_req
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
    } cmd_reg_t;

    cmd_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cmd_we) begin
            r_d.cmd = cmd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ring_mode = r_q.cmd[CMD_SEL] & ~r_q.cmd[CMD_EXCL];
    assign ring_req  = ring_mode & r_q.cmd[CMD_REQ];

    // R1
    mode_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (ring_mode == ($past(cmd_data[CMD_SEL]) & ~$past(cmd_data[CMD_EXCL]))));

    // R2
    req_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_req |-> ring_mode);

endmodule

// File: rtl/ring_trip_fsm.sv
module ring_trip_fsm
    import ring_pkg::*;
#(
    parameter int ZC_PER_WINDOW = 4
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       ring_req,
    input  logic       zc_pulse,
    input  logic       loop_closed,
    output seq_state_e state,
    output logic       suppress,
    output logic       trip_flag
);

    localparam int CNT_W = $clog2(ZC_PER_WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ZC_PER_WINDOW - 1);
    localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(ZC_PER_WINDOW);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cmd_we) begin
            s_d.st   = SEQ_IDLE;
            s_d.cnt  = '0;
            s_d.flag = 1'b0;
        end else begin
            unique case (s_q.st)
                SEQ_IDLE: begin
                    if (ring_req) s_d.st = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (!ring_req) begin
                        s_d.st = SEQ_IDLE;
                    end else if (loop_closed) begin
                        s_d.st  = SEQ_CHECK;
                        s_d.cnt = '0;
                    end
                end
                SEQ_CHECK: begin
                    if (!loop_closed) begin
                        s_d.st  = SEQ_ARMED;
                        s_d.cnt = '0;
                    end else if (zc_pulse) begin
                        if (s_q.cnt == CNT_LAST) begin
                            s_d.st   = SEQ_TRIPPED;
                            s_d.cnt  = '0;
                            s_d.flag = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                SEQ_TRIPPED: begin
                    s_d.st = SEQ_TRIPPED;
                end
                default: s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, cnt: '0, flag: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state     = s_q.st;
    assign suppress  = (s_q.st == SEQ_CHECK) || (s_q.st == SEQ_TRIPPED);
    assign trip_flag = s_q.flag;

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_flag) |-> ($past(s_q.st == SEQ_CHECK) && $past(zc_pulse) && $past(loop_closed)));

    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_LIM);

    // R7
    abort_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_CHECK && !loop_closed && !cmd_we) |=> (s_q.st == SEQ_ARMED && !trip_flag));

    // R8
    tripped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_TRIPPED && !cmd_we) |=> (s_q.st == SEQ_TRIPPED && trip_flag));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (!trip_flag && s_q.st == SEQ_IDLE));

endmodule

// File: rtl/ring_gate.sv
module ring_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_req,
    input  logic suppress,
    input  logic zc_pulse,
    output logic ring_en
);

    typedef struct packed {
        logic en;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (suppress) begin
            g_d.en = 1'b0;
        end else if (zc_pulse) begin
            g_d.en = ring_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ring_en = g_q.en;

    // R3
    start_on_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_en) |-> $past(zc_pulse));

    // R4
    stop_on_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ring_en) |-> ($past(zc_pulse) || $past(suppress)));

endmodule

// File: rtl/ring_cadence_seq.sv
module ring_cadence_seq
    import ring_pkg::*;
#(
    parameter int ZC_PER_WINDOW = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             zc_pulse,
    input  logic             loop_closed,
    output logic             ring_en,
    output logic             ring_mode,
    output logic             trip_flag
);

    logic       ring_req;
    logic       suppress;
    seq_state_e seq_state;

    ring_cmd_reg i_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_data  (cmd_data),
        .ring_mode (ring_mode),
        .ring_req  (ring_req)
    );

    ring_trip_fsm #(
        .ZC_PER_WINDOW (ZC_PER_WINDOW)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .ring_req    (ring_req),
        .zc_pulse    (zc_pulse),
        .loop_closed (loop_closed),
        .state       (seq_state),
        .suppress    (suppress),
        .trip_flag   (trip_flag)
    );

    ring_gate i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring_req (ring_req),
        .suppress (suppress),
        .zc_pulse (zc_pulse),
        .ring_en  (ring_en)
    );

    // R5
    closure_cuts_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_ARMED && loop_closed && !cmd_we) |=> ##1 (!ring_en && ring_mode));

    // R8
    tripped_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_TRIPPED) |=> (seq_state != SEQ_TRIPPED || !ring_en));

endmodule

// File: tb/test_ring_cadence_seq.sv
module test_ring_cadence_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd_data = 3'd0;
    logic       zc_pulse = 1'b0;
    logic       loop_closed = 1'b0;
    logic       ring_en;
    logic       ring_mode;
    logic       trip_flag;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    ring_cadence_seq #(.ZC_PER_WINDOW(4)) i_ring_cadence_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_data    (cmd_data),
        .zc_pulse    (zc_pulse),
        .loop_closed (loop_closed),
        .ring_en     (ring_en),
        .ring_mode   (ring_mode),
        .trip_flag   (trip_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmd(input logic [2:0] v);
        cmd_we = 1'b1;
        cmd_data = v;
        step(1);
        cmd_we = 1'b0;
    endtask

    task automatic pulse_zc();
        zc_pulse = 1'b1;
        step(1);
        zc_pulse = 1'b0;
    endtask

    task automatic ring_off();
        loop_closed = 1'b0;
        write_cmd(3'd0);
        step(1);
        pulse_zc();
        step(1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("reset ring_en", ring_en, 1'b0);
        check("reset ring_mode", ring_mode, 1'b0);
        check("reset trip_flag", trip_flag, 1'b0);

        // R1 R2 R3 R4: sweep all command words
        for (int v = 0; v < 8; v++) begin
            logic [2:0] w;
            logic mode_e, ring_e;
            w = 3'(v);
            mode_e = w[2] & ~w[0];
            ring_e = mode_e & w[1];
            ring_off();
            write_cmd(w);
            check("R1 ring_mode decode", ring_mode, mode_e);
            step(5);
            check("R3 start waits for zero crossing", ring_en, 1'b0);
            pulse_zc();
            check("R2 ring request decode", ring_en, ring_e);
            step(3);
            pulse_zc();
            check("R2 ring_en steady", ring_en, ring_e);
            write_cmd(w & 3'b101);
            step(4);
            check("R4 stop pending until zero crossing", ring_en, ring_e);
            pulse_zc();
            check("R4 stop at zero crossing", ring_en, 1'b0);
            check("R1 mode kept without request", ring_mode, mode_e);
        end

        // R5 R6 R7 R8 R9 R10: every abort point at two pulse spacings
        for (int g = 0; g < 2; g++) begin
            int gap;
            gap = (g == 0) ? 2 : 30;
            for (int k = 0; k <= 4; k++) begin
                ring_off();
                write_cmd(3'b110);
                step(1);
                pulse_zc();
                check("R3 ringing active before closure", ring_en, 1'b1);
                step(gap);
                loop_closed = 1'b1;
                step(2);
                check("R5 closure cuts ringing", ring_en, 1'b0);
                check("R5 mode held during check", ring_mode, 1'b1);
                for (int p = 1; p <= k; p++) begin
                    step(gap);
                    pulse_zc();
                    check(p < 4 ? "R10 no early confirm" : "R6 confirm on fourth pulse",
                          trip_flag, (p == 4) ? 1'b1 : 1'b0);
                    check("R5 ringing held off", ring_en, 1'b0);
                end
                if (k < 4) begin
                    loop_closed = 1'b0;
                    step(gap);
                    check("R7 no resume before zero crossing", ring_en, 1'b0);
                    pulse_zc();
                    check("R7 resume at zero crossing", ring_en, 1'b1);
                    check("R7 flag not set", trip_flag, 1'b0);
                end else begin
                    step(gap);
                    pulse_zc();
                    check("R8 silent after trip", ring_en, 1'b0);
                    loop_closed = 1'b0;
                    step(gap);
                    pulse_zc();
                    check("R8 silent after hang-up", ring_en, 1'b0);
                    check("R8 flag held", trip_flag, 1'b1);
                    write_cmd(3'b110);
                    check("R9 write clears flag", trip_flag, 1'b0);
                    step(1);
                    pulse_zc();
                    check("R9 ringing restarts", ring_en, 1'b1);
                end
            end
        end

        // R9: write that removes ringing mode clears a confirmed trip
        ring_off();
        write_cmd(3'b110);
        step(1);
        pulse_zc();
        loop_closed = 1'b1;
        step(2);
        for (int p = 0; p < 4; p++) begin
            step(2);
            pulse_zc();
        end
        check("R6 flag before mode clear", trip_flag, 1'b1);
        loop_closed = 1'b0;
        write_cmd(3'b000);
        check("R9 mode clear drops flag", trip_flag, 1'b0);
        check("R1 mode cleared", ring_mode, 1'b0);
        pulse_zc();
        check("R2 no ring after mode clear", ring_en, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule